// File: doc/BRIEF.md
# Phase-Synchronized Complementary PWM Channel

This block is one PWM channel with a down-counting time base, compare-based waveform generation and a dead-band stage. The counter counts down from a period value to zero and then reloads. The counter value is compared against a compare value to build a raw PWM level. The raw level is low from the zero event and high from the compare match. The dead-band stage turns the raw level into an active-high complementary pair. Output A gets a programmable delay on its rising edge. Output B is the inverted level with its own delay, so it also rises late.

Several channels can be chained. A master runs with phase loading off and sends its counter-zero event out. Each slave has phase loading on, so a sync pulse forces its counter to a programmed phase value. A slave can either pass the received sync straight on or send out its own zero event. Period and phase writes go into holding registers, and compare writes go into a shadow register. As a result, no write disturbs a count that is in progress.

Top module: `pwmch_top`

## Requirements
- R1: While reset is active and until the internal reset release two clocks after `rst_n` rises, `cnt_o` is 0 and both `pwm_a` and `pwm_b` are low. After that, when no phase load occurs, a nonzero count decreases by exactly one per clock.
- R2: The raw level is forced low on the clock after the count is 0. It is set high on the clock after the count equals the active compare value, unless the count is 0. Otherwise it keeps its value.
- R3: A `cmp_wr` pulse updates only the compare shadow. The active compare value takes the shadow value only on a clock where the count is 0.
- R4: A `prd_wr` pulse updates only the period holding register. On a clock where the count is 0, the counter reloads from the holding register, and the active period takes that same value.
- R5: When `phs_en` is 1 and `sync_in` is 1, the next count is the phase holding value, clamped to at most the active period. This load takes priority over the zero reload. When `phs_en` is 0, `sync_in` has no effect on the count.
- R6: `sync_out` equals `sync_in` in the same cycle when `sync_sel` is 1. When `sync_sel` is 0, `sync_out` is 1 exactly while `cnt_o` is 0.
- R7: `pwm_a` is high in a cycle only if the raw level has been high for the preceding `red`+1 consecutive clocks. It falls on the clock after the raw level falls.
- R8: `pwm_b` is high in a cycle only if the raw level has been low for the preceding `fed`+1 consecutive clocks. It falls on the clock after the raw level rises.
- R9: `pwm_a` and `pwm_b` are never high together. A raw pulse shorter than or equal to the relevant delay produces no pulse at all on that output.
- R10: After reset the active and holding period is 4999, the compare value is 2500, the phase value is 0, and both delays are 100. A `db_wr` pulse loads `red_in` and `fed_in`, and the new values take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for counter and delay logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prd_wr | input | 1 | Write strobe for the period holding register |
| prd_in | input | CNT_W | New period value |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| cmp_in | input | CNT_W | New compare value |
| phs_wr | input | 1 | Write strobe for the phase holding register |
| phs_in | input | CNT_W | New phase value |
| phs_en | input | 1 | Enables counter load on sync |
| sync_sel | input | 1 | 0: send own zero event out, 1: pass sync_in through |
| db_wr | input | 1 | Write strobe for both dead-band delays |
| red_in | input | DB_W | Rising-edge delay for output A, in clocks |
| fed_in | input | DB_W | Rising-edge delay for output B (falling edge of raw), in clocks |
| sync_in | input | 1 | Sync pulse from the previous channel |
| sync_out | output | 1 | Sync pulse to the next channel |
| cnt_o | output | CNT_W | Current time-base count |
| pwm_a | output | 1 | Active-high output A |
| pwm_b | output | 1 | Active-high complementary output B |

## Verification
The assertions assume that the write strobes, mode inputs and `sync_in` change only between clock edges, and that `sync_in` is a level the channel samples once per clock. The assertions make no assumption about its pulse width. The stimulus drives every input on the falling clock edge, so each value holds steady for a full sampling window. The random phase keeps periods small, below 251, so that many zero events, compare matches, clamped phase loads and suppressed dead-band pulses occur. It also includes compare values above the period, which never match, and a period of zero.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

  // Source of the outgoing sync pulse
  typedef enum logic {
    SYNC_FROM_ZERO = 1'b0,
    SYNC_PASS      = 1'b1
  } sync_src_e;

  // Index of each dead-band delay unit
  typedef enum int unsigned {
    EDGE_A = 0,
    EDGE_B = 1
  } edge_idx_e;

  localparam int unsigned NUM_EDGES = 2;

endpackage

// File: rtl/pwmch_edge_delay.sv
// Delays the rising edge of a level by a programmable count; falls at once.
module pwmch_edge_delay #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sig,
  input  logic [DB_W-1:0] dly,
  output logic            dout
);

  logic [DB_W-1:0] run_q, run_d;
  logic            out_q, out_d;

  always_comb begin
    run_d = run_q;
    out_d = out_q;
    if (!sig) begin
      run_d = '0;
      out_d = 1'b0;
    end else if (run_q >= dly) begin
      out_d = 1'b1;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/pwmch_timebase.sv
// Down counter with held period, phase load on sync and zero reload.
module pwmch_timebase #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRD_RST = 4999,
  parameter int unsigned PHS_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_in,
  input  logic             phs_wr,
  input  logic [CNT_W-1:0] phs_in,
  input  logic             phs_en,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  localparam logic [CNT_W-1:0] PRD_INIT = CNT_W'(PRD_RST);
  localparam logic [CNT_W-1:0] PHS_INIT = CNT_W'(PHS_RST);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] prd_hold_q, prd_act_q, phs_q;
  logic [CNT_W-1:0] phs_lim;
  logic             load;

  always_comb begin
    zero    = (cnt_q == '0);
    load    = phs_en & sync_in;
    phs_lim = (phs_q > prd_act_q) ? prd_act_q : phs_q;
    if (load)      cnt_d = phs_lim;
    else if (zero) cnt_d = prd_hold_q;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      prd_hold_q <= PRD_INIT;
      prd_act_q  <= PRD_INIT;
      phs_q      <= PHS_INIT;
    end else begin
      cnt_q <= cnt_d;
      if (prd_wr) prd_hold_q <= prd_in;
      if (zero)   prd_act_q  <= prd_hold_q;
      if (phs_wr) phs_q      <= phs_in;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwmch_compare.sv
// Shadowed compare and the zero/match action that forms the raw level.
module pwmch_compare #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CMP_RST = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             zero,
  output logic [CNT_W-1:0] cmp_act,
  output logic             raw
);

  localparam logic [CNT_W-1:0] CMP_INIT = CNT_W'(CMP_RST);

  logic [CNT_W-1:0] shadow_q, act_q;
  logic             raw_q, raw_d;
  logic             hit;

  always_comb begin
    hit   = (cnt == act_q);
    raw_d = raw_q;
    if (zero)     raw_d = 1'b0;
    else if (hit) raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= CMP_INIT;
      act_q    <= CMP_INIT;
      raw_q    <= 1'b0;
    end else begin
      raw_q <= raw_d;
      if (cmp_wr) shadow_q <= cmp_in;
      if (zero)   act_q    <= shadow_q;
    end
  end

  assign cmp_act = act_q;
  assign raw     = raw_q;

endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DB_W    = 8,
  parameter int unsigned PRD_RST = 4999,
  parameter int unsigned CMP_RST = 2500,
  parameter int unsigned PHS_RST = 0,
  parameter int unsigned DB_RST  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_in,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             phs_wr,
  input  logic [CNT_W-1:0] phs_in,
  input  logic             phs_en,
  input  logic             sync_sel,
  input  logic             db_wr,
  input  logic [DB_W-1:0]  red_in,
  input  logic [DB_W-1:0]  fed_in,
  input  logic             sync_in,
  output logic             sync_out,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_a,
  output logic             pwm_b
);

  localparam logic [DB_W-1:0] DB_INIT = DB_W'(DB_RST);

  // Reset release synchronizer
  logic rs_q1, rs_q2, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  assign srst_n = rs_q2;

  logic             zero_evt;
  logic [CNT_W-1:0] cmp_act;
  logic             raw_pwm;

  pwmch_timebase #(
    .CNT_W   (CNT_W),
    .PRD_RST (PRD_RST),
    .PHS_RST (PHS_RST)
  ) u_tb (
    .clk     (clk),
    .rst_n   (srst_n),
    .prd_wr  (prd_wr),
    .prd_in  (prd_in),
    .phs_wr  (phs_wr),
    .phs_in  (phs_in),
    .phs_en  (phs_en),
    .sync_in (sync_in),
    .cnt     (cnt_o),
    .zero    (zero_evt)
  );

  pwmch_compare #(
    .CNT_W   (CNT_W),
    .CMP_RST (CMP_RST)
  ) u_cmp (
    .clk     (clk),
    .rst_n   (srst_n),
    .cmp_wr  (cmp_wr),
    .cmp_in  (cmp_in),
    .cnt     (cnt_o),
    .zero    (zero_evt),
    .cmp_act (cmp_act),
    .raw     (raw_pwm)
  );

  // Sync routing
  sync_src_e sync_src;
  assign sync_src = sync_src_e'(sync_sel);

  always_comb begin
    case (sync_src)
      SYNC_PASS: sync_out = sync_in;
      default:   sync_out = zero_evt;
    endcase
  end

  // Dead-band delays, one per output edge
  logic [NUM_EDGES-1:0][DB_W-1:0] dly_q;
  logic [NUM_EDGES-1:0]           db_src;
  logic [NUM_EDGES-1:0]           db_out;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dly_q[EDGE_A] <= DB_INIT;
      dly_q[EDGE_B] <= DB_INIT;
    end else if (db_wr) begin
      dly_q[EDGE_A] <= red_in;
      dly_q[EDGE_B] <= fed_in;
    end
  end

  assign db_src[EDGE_A] = raw_pwm;
  assign db_src[EDGE_B] = ~raw_pwm;

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_edge
    pwmch_edge_delay #(
      .DB_W (DB_W)
    ) u_dly (
      .clk   (clk),
      .rst_n (srst_n),
      .sig   (db_src[g]),
      .dly   (dly_q[g]),
      .dout  (db_out[g])
    );
  end

  assign pwm_a = db_out[EDGE_A];
  assign pwm_b = db_out[EDGE_B];

endmodule

// File: rtl/pwmch_chk.sv
module pwmch_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             raw,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             sync_in,
  input logic             phs_en
);

  // R9
  excl_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_a && pwm_b));

  // R1
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !(phs_en && sync_in)) |=> (cnt == $past(cnt) - 1'b1));

  // R2
  raw_low_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> !raw);

  // R3
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(cmp_act));

  // R7
  a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !pwm_a);

  // R8
  b_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw |=> !pwm_b);

endmodule

bind pwmch_top pwmch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .cnt     (cnt_o),
  .raw     (raw_pwm),
  .cmp_act (cmp_act),
  .pwm_a   (pwm_a),
  .pwm_b   (pwm_b),
  .sync_in (sync_in),
  .phs_en  (phs_en)
);

// File: tb/tb_pwmch_top.sv
`timescale 1ns/1ps
module tb_pwmch_top;

  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          prd_wr, cmp_wr, phs_wr, db_wr;
  logic [CW-1:0] prd_in, cmp_in, phs_in;
  logic          phs_en, sync_sel, sync_in;
  logic [DW-1:0] red_in, fed_in;
  logic          sync_out, pwm_a, pwm_b;
  logic [CW-1:0] cnt_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  pwmch_top dut (
    .clk(clk), .rst_n(rst_n),
    .prd_wr(prd_wr), .prd_in(prd_in),
    .cmp_wr(cmp_wr), .cmp_in(cmp_in),
    .phs_wr(phs_wr), .phs_in(phs_in),
    .phs_en(phs_en), .sync_sel(sync_sel),
    .db_wr(db_wr), .red_in(red_in), .fed_in(fed_in),
    .sync_in(sync_in), .sync_out(sync_out),
    .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model state
  logic          m_s1, m_s2;
  logic [CW-1:0] m_cnt, m_prd_act, m_prd_hold, m_phs, m_cmp_sh, m_cmp_act;
  logic          m_raw, m_a, m_b;
  logic [DW-1:0] m_ca, m_cb, m_red, m_fed;

  function automatic void model_reset();
    m_cnt = '0; m_prd_act = 16'd4999; m_prd_hold = 16'd4999; m_phs = '0;
    m_cmp_sh = 16'd2500; m_cmp_act = 16'd2500; m_raw = 1'b0;
    m_a = 1'b0; m_b = 1'b0; m_ca = '0; m_cb = '0; m_red = 8'd100; m_fed = 8'd100;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1'b0; m_s2 = 1'b0; model_reset();
    end else begin
      if (!m_s2) model_reset();
      else begin
        logic          zero, load;
        logic [CW-1:0] lim, n_cnt;
        logic          n_raw, n_a, n_b;
        logic [DW-1:0] n_ca, n_cb;
        zero  = (m_cnt == '0);
        load  = phs_en && sync_in;
        lim   = (m_phs > m_prd_act) ? m_prd_act : m_phs;
        n_cnt = load ? lim : (zero ? m_prd_hold : m_cnt - 16'd1);
        n_raw = zero ? 1'b0 : ((m_cnt == m_cmp_act) ? 1'b1 : m_raw);
        n_a = m_a; n_ca = m_ca;
        if (!m_raw) begin n_ca = '0; n_a = 1'b0; end
        else if (m_ca >= m_red) n_a = 1'b1;
        else n_ca = m_ca + 8'd1;
        n_b = m_b; n_cb = m_cb;
        if (m_raw) begin n_cb = '0; n_b = 1'b0; end
        else if (m_cb >= m_fed) n_b = 1'b1;
        else n_cb = m_cb + 8'd1;
        if (zero) begin m_prd_act = m_prd_hold; m_cmp_act = m_cmp_sh; end
        if (prd_wr) m_prd_hold = prd_in;
        if (phs_wr) m_phs = phs_in;
        if (cmp_wr) m_cmp_sh = cmp_in;
        if (db_wr) begin m_red = red_in; m_fed = fed_in; end
        m_cnt = n_cnt; m_raw = n_raw;
        m_a = n_a; m_ca = n_ca; m_b = n_b; m_cb = n_cb;
      end
      m_s2 = m_s1; m_s1 = 1'b1;
    end
  end

  function automatic logic [CW+2:0] expected();
    logic so;
    so = sync_sel ? sync_in : (m_cnt == '0);
    return {m_cnt, m_a, m_b, so};
  endfunction

  task automatic step(input string tag);
    logic [CW+2:0] act, exp;
    @(negedge clk);
    act = {cnt_o, pwm_a, pwm_b, sync_out};
    exp = expected();
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cnt/a/b/sync actual=%0d/%b/%b/%b expected=%0d/%b/%b/%b", tag,
               act[CW+2:3], act[2], act[1], act[0], exp[CW+2:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wr_prd(input int v);
    prd_in = CW'(v); prd_wr = 1'b1; step("R4"); prd_wr = 1'b0;
  endtask
  task automatic wr_cmp(input int v);
    cmp_in = CW'(v); cmp_wr = 1'b1; step("R3"); cmp_wr = 1'b0;
  endtask
  task automatic wr_phs(input int v);
    phs_in = CW'(v); phs_wr = 1'b1; step("R5"); phs_wr = 1'b0;
  endtask
  task automatic wr_db(input int r, input int f);
    red_in = DW'(r); fed_in = DW'(f); db_wr = 1'b1; step("R10"); db_wr = 1'b0;
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    prd_wr = 0; cmp_wr = 0; phs_wr = 0; db_wr = 0;
    prd_in = '0; cmp_in = '0; phs_in = '0; red_in = '0; fed_in = '0;
    phs_en = 0; sync_sel = 0; sync_in = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    run("R1", 4);                 // reset state: count 0, outputs low
    rst_n = 1'b1;
    run("R1", 3);                 // synchronizer release window
    run("R10", 5200);             // default period, compare and delays
    run("R2", 5000);              // default 50 % duty

    // Period and compare updates mid-count
    wr_prd(99);
    run("R4", 5200);
    wr_cmp(30);
    run("R3", 40);
    wr_cmp(70);
    run("R3", 300);
    wr_prd(0);                    // zero period corner
    run("R4", 60);
    wr_prd(99);
    run("R4", 300);

    // Dead-band delays
    wr_db(5, 12);
    run("R7", 300);
    wr_db(0, 0);
    run("R8", 300);
    wr_cmp(3); wr_db(8, 2);       // A pulse shorter than delay
    run("R9", 300);
    wr_cmp(97); wr_db(2, 5);      // B pulse shorter than delay
    run("R9", 300);
    wr_cmp(50); wr_db(4, 4);

    // Phase loading
    phs_en = 1'b1;
    wr_phs(40);
    for (int k = 0; k < 6; k++) begin
      run("R5", 69); sync_in = 1'b1; step("R5"); sync_in = 1'b0;
    end
    wr_phs(500);                  // clamped to the period
    for (int k = 0; k < 4; k++) begin
      run("R5", 33); sync_in = 1'b1; step("R5"); sync_in = 1'b0;
    end
    phs_en = 1'b0;                // sync ignored
    for (int k = 0; k < 4; k++) begin
      run("R5", 21); sync_in = 1'b1; step("R5"); sync_in = 1'b0;
    end

    // Sync routing
    sync_sel = 1'b1;
    for (int k = 0; k < 200; k++) begin
      sync_in = ($urandom_range(0, 3) == 0); step("R6");
    end
    sync_in = 1'b0; sync_sel = 1'b0;
    run("R6", 200);

    // Constrained random
    for (int k = 0; k < 40000; k++) begin
      prd_wr = ($urandom_range(0, 199) == 0); prd_in = CW'($urandom_range(0, 250));
      cmp_wr = ($urandom_range(0, 99) == 0);  cmp_in = CW'($urandom_range(0, 260));
      phs_wr = ($urandom_range(0, 99) == 0);  phs_in = CW'($urandom_range(0, 300));
      db_wr  = ($urandom_range(0, 299) == 0);
      red_in = DW'($urandom_range(0, 15)); fed_in = DW'($urandom_range(0, 15));
      if ($urandom_range(0, 499) == 0) phs_en = ~phs_en;
      if ($urandom_range(0, 499) == 0) sync_sel = ~sync_sel;
      sync_in = ($urandom_range(0, 49) == 0);
      step("R2");
    end
    prd_wr = 0; cmp_wr = 0; phs_wr = 0; db_wr = 0; sync_in = 0;
    run("R9", 50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule